// File: doc/BRIEF.md
# DShot Telemetry Reply Receiver

This block listens on a motor line after a bidirectional command frame has been sent and the line has been handed back. It recovers the speed reply that the motor controller drives back. A one-cycle start strobe from the transmitter arms the receiver. The first transition seen on the line then starts a bit-period counter. That counter is re-aligned on every rising edge of the line, and each bit is sampled at the middle of its period. The line is active low, and the reply runs at its own bit period, which the caller supplies in clock cycles (5/4 of the command bit rate).

After the capture, the word is complemented and checked for framing. The transition code is removed by XOR-ing the word with itself shifted right by one. Each 5-bit group is then mapped to a nibble, and the folded nibble checksum is verified. A good reply produces a 12-bit eRPM value with a single-cycle valid pulse. A bad reply increments a framing or checksum error counter instead. If a new start strobe arrives while the previous reply is still outstanding, a missing-reply counter increments. All three counters saturate.

Top module: `dshot_reply_rx`

## Requirements
- R1: After reset, erpm_o is 0, erpm_valid_o is low and all three counters are 0.
- R2: A start_i pulse arms the receiver. The first change of the synchronised line opens a frame. The line is sampled once every bit_div_i cycles, at the middle of each bit period, 21 times in all. The first sample is the low start bit and is dropped. The remaining 20 samples form the raw word, first received bit in bit 19.
- R3: Every rising edge of the line during a frame re-aligns the bit-period counter to a bit boundary. As a result, a line whose bit period is one cycle longer than bit_div_i (with bit_div_i of 16) still decodes correctly.
- R4: The raw word is complemented. If bit 0 of the complement is 0, the framing-error counter increments and no valid pulse is produced.
- R5: The complemented word w is decoded as d = w XOR (w >> 1). Bits 4:0 of d give nibble 0 and bits 19:15 give nibble 3. The codes map to nibbles as follows: 9, 10, 11, 13, 14 and 15 map to themselves; 27→1, 18→2, 19→3, 29→4, 21→5, 22→6, 23→7, 26→8, 30→C; every other code maps to 0.
- R6: The checksum passes when the XOR of the four nibbles of the 16-bit result equals 0xF. If it fails, the checksum-error counter increments and no valid pulse is produced.
- R7: If the checksum passes, erpm_o takes the complement of result bits 15:4, and erpm_valid_o is high for exactly one cycle. erpm_o changes only together with a valid pulse.
- R8: A start_i pulse that arrives while the receiver is armed or mid-frame increments the missing-reply counter and re-arms the receiver.
- R9: Each counter is CNT_W bits wide, steps by exactly one, and holds at its all-ones value.
- R10: Line activity while the receiver is not armed produces no valid pulse and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw line level (asynchronous, active low, idles high) |
| start_i | input | 1 | One-cycle strobe: command sent, expect a reply |
| bit_div_i | input | DIV_W | Reply bit period in clock cycles (at least 4) |
| erpm_o | output | 12 | Last decoded eRPM value |
| erpm_valid_o | output | 1 | One-cycle pulse when erpm_o is updated |
| crc_err_cnt_o | output | CNT_W | Saturating count of checksum failures |
| frame_err_cnt_o | output | CNT_W | Saturating count of framing failures |
| miss_cnt_o | output | CNT_W | Saturating count of missing replies |

## Verification
The bench drives a line whose bit period is one cycle too long. A receiver that only free-runs its bit counter and never re-aligns on rising edges drifts out of its bit and reports a checksum or framing error where a valid value is expected. Replies are built through the GCR and transition encoding, and frames with a wrong checksum nibble or a cleared bit 0 are mixed in. A swapped table entry, a decode that shifts the wrong way, or a frame check on the wrong bit therefore shows up as a wrong eRPM value or a wrong error counter. The bench also aborts a reply mid-frame with a new strobe, repeats strobes and error frames until the counters saturate, and toggles the line while the receiver is disarmed. These catch a counter that wraps to zero, a missing-reply count that ignores a partial frame, and a receiver that starts on an unarmed edge.

// File: rtl/dshot_reply_rx.sv
module dshot_reply_rx #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] bit_div_i,
  output logic [11:0]      erpm_o,
  output logic             erpm_valid_o,
  output logic [CNT_W-1:0] crc_err_cnt_o,
  output logic [CNT_W-1:0] frame_err_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);

  localparam int FRAME_BITS = 20;
  localparam int SAMPLES    = FRAME_BITS + 1;
  localparam int SCNT_W     = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RECV, S_DECODE} st_t;

  function automatic logic [3:0] gcr_nib(input logic [4:0] c);
    case (c)
      5'd9:    return 4'h9;
      5'd10:   return 4'hA;
      5'd11:   return 4'hB;
      5'd13:   return 4'hD;
      5'd14:   return 4'hE;
      5'd15:   return 4'hF;
      5'd18:   return 4'h2;
      5'd19:   return 4'h3;
      5'd21:   return 4'h5;
      5'd22:   return 4'h6;
      5'd23:   return 4'h7;
      5'd26:   return 4'h8;
      5'd27:   return 4'h1;
      5'd29:   return 4'h4;
      5'd30:   return 4'hC;
      default: return 4'h0;
    endcase
  endfunction

  st_t                   st;
  logic                  s1, s2, s3;
  logic [DIV_W-1:0]      phase;
  logic [SCNT_W-1:0]     nsamp;
  logic [FRAME_BITS-1:0] shreg;

  wire line_edge = s2 ^ s3;
  wire line_rise = s2 & ~s3;
  wire [DIV_W-1:0] half    = bit_div_i >> 1;
  wire [DIV_W-1:0] last_ph = bit_div_i - DIV_W'(1);
  wire sample_now = (st == S_RECV) && !line_rise && (phase == half);

  wire [FRAME_BITS-1:0] inv = ~shreg;
  wire [FRAME_BITS-1:0] rl  = inv ^ (inv >> 1);
  wire [15:0] val16 = {gcr_nib(rl[19:15]), gcr_nib(rl[14:10]),
                       gcr_nib(rl[9:5]),   gcr_nib(rl[4:0])};
  wire framed = inv[0];
  wire ck_ok  = (val16[15:12] ^ val16[11:8] ^ val16[7:4] ^ val16[3:0]) == 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      phase           <= '0;
      nsamp           <= '0;
      shreg           <= '0;
      erpm_o          <= '0;
      erpm_valid_o    <= 1'b0;
      crc_err_cnt_o   <= '0;
      frame_err_cnt_o <= '0;
      miss_cnt_o      <= '0;
    end else begin
      erpm_valid_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) st <= S_ARMED;
        end
        S_ARMED: begin
          if (start_i) begin
            if (miss_cnt_o != CNT_MAX) miss_cnt_o <= miss_cnt_o + 1'b1;
          end else if (line_edge) begin
            st    <= S_RECV;
            phase <= DIV_W'(1);
            nsamp <= '0;
          end
        end
        S_RECV: begin
          if (start_i) begin
            if (miss_cnt_o != CNT_MAX) miss_cnt_o <= miss_cnt_o + 1'b1;
            st <= S_ARMED;
          end else begin
            if (line_rise)             phase <= DIV_W'(1);
            else if (phase >= last_ph) phase <= '0;
            else                       phase <= phase + 1'b1;
            if (sample_now) begin
              shreg <= {shreg[FRAME_BITS-2:0], s2};
              nsamp <= nsamp + 1'b1;
              if (nsamp == SCNT_W'(SAMPLES - 1)) st <= S_DECODE;
            end
          end
        end
        S_DECODE: begin
          st <= start_i ? S_ARMED : S_IDLE;
          if (!framed) begin
            if (frame_err_cnt_o != CNT_MAX) frame_err_cnt_o <= frame_err_cnt_o + 1'b1;
          end else if (!ck_ok) begin
            if (crc_err_cnt_o != CNT_MAX) crc_err_cnt_o <= crc_err_cnt_o + 1'b1;
          end else begin
            erpm_o       <= ~val16[15:4];
            erpm_valid_o <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    erpm_valid_o |=> !erpm_valid_o); // R7
  AST_ERPM_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(erpm_o) |-> erpm_valid_o); // R7
  AST_VALID_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    erpm_valid_o |-> ($stable(crc_err_cnt_o) && $stable(frame_err_cnt_o))); // R6
  AST_MISS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_cnt_o) |-> $past(start_i)); // R8
  AST_CRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_err_cnt_o) |-> crc_err_cnt_o == $past(crc_err_cnt_o) + 1'b1); // R9
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err_cnt_o) |-> frame_err_cnt_o == $past(frame_err_cnt_o) + 1'b1); // R9
  AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt_o == CNT_MAX) |=> (miss_cnt_o == CNT_MAX)); // R9

endmodule

// File: tb/dshot_reply_rx_tb.sv
module dshot_reply_rx_tb;
  localparam int DIV_W = 16;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b1;
  logic start_i = 1'b0;
  logic [DIV_W-1:0] bit_div_i = 16'd8;
  logic [11:0] erpm_o;
  logic erpm_valid_o;
  logic [CNT_W-1:0] crc_err_cnt_o, frame_err_cnt_o, miss_cnt_o;

  int checks = 0;
  int failures = 0;
  int vcnt = 0;
  logic [11:0] vlast = '0;
  logic [CNT_W-1:0] exp_crc = '0, exp_frm = '0, exp_miss = '0;
  logic pending = 1'b0;

  always #5 clk = ~clk;

  dshot_reply_rx #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .start_i(start_i),
    .bit_div_i(bit_div_i), .erpm_o(erpm_o), .erpm_valid_o(erpm_valid_o),
    .crc_err_cnt_o(crc_err_cnt_o), .frame_err_cnt_o(frame_err_cnt_o),
    .miss_cnt_o(miss_cnt_o));

  always @(negedge clk) if (erpm_valid_o) begin vcnt++; vlast = erpm_o; end

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'd25; 4'h1: return 5'd27; 4'h2: return 5'd18; 4'h3: return 5'd19;
      4'h4: return 5'd29; 4'h5: return 5'd21; 4'h6: return 5'd22; 4'h7: return 5'd23;
      4'h8: return 5'd26; 4'h9: return 5'd9;  4'hA: return 5'd10; 4'hB: return 5'd11;
      4'hC: return 5'd30; 4'hD: return 5'd13; 4'hE: return 5'd14; default: return 5'd15;
    endcase
  endfunction

  function automatic logic [3:0] dec(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (c != 5'd25 && enc(4'(n)) == c) return 4'(n);
    return 4'h0;
  endfunction

  function automatic logic [19:0] build(input logic [11:0] p, input logic [3:0] c);
    logic [15:0] v;
    logic [19:0] d, w;
    v = {p, c};
    d = {enc(v[15:12]), enc(v[11:8]), enc(v[7:4]), enc(v[3:0])};
    w[19] = d[19];
    for (int i = 18; i >= 0; i--) w[i] = d[i] ^ w[i+1];
    return w;
  endfunction

  // kind: 0 valid, 1 checksum error, 2 framing error; w is the complemented word
  function automatic logic [13:0] model(input logic [19:0] w);
    logic [19:0] d;
    logic [15:0] v;
    if (!w[0]) return {2'd2, 12'h0};
    d = w ^ (w >> 1);
    v = {dec(d[19:15]), dec(d[14:10]), dec(d[9:5]), dec(d[4:0])};
    if ((v[15:12] ^ v[11:8] ^ v[7:4] ^ v[3:0]) != 4'hF) return {2'd1, 12'h0};
    return {2'd0, ~v[15:4]};
  endfunction

  function automatic logic [CNT_W-1:0] sinc(input logic [CNT_W-1:0] x);
    return (x == CMAX) ? x : x + 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (pending) exp_miss = sinc(exp_miss);
    pending = 1'b1;
  endtask

  task automatic send(input logic [19:0] w, input int len, input int nbits);
    @(negedge clk) line_i = 1'b0;
    repeat (len - 1) @(negedge clk);
    for (int i = 19; i > 19 - nbits; i--) begin
      line_i = ~w[i];
      repeat (len) @(negedge clk);
    end
    line_i = 1'b1;
  endtask

  task automatic check_counters(input string tag);
    chk(crc_err_cnt_o == exp_crc, {tag, " crc count"}, crc_err_cnt_o, exp_crc);
    chk(frame_err_cnt_o == exp_frm, {tag, " frame count"}, frame_err_cnt_o, exp_frm);
    chk(miss_cnt_o == exp_miss, {tag, " miss count"}, miss_cnt_o, exp_miss);
  endtask

  task automatic do_frame(input logic [19:0] w, input int div, input int len, input string tag);
    logic [13:0] m;
    m = model(w);
    bit_div_i = DIV_W'(div);
    pulse_start();
    repeat (3) @(negedge clk);
    vcnt = 0;
    send(w, len, 20);
    repeat (2 * div + 6) @(negedge clk);
    pending = 1'b0;
    if (m[13:12] == 2'd2) exp_frm = sinc(exp_frm);
    if (m[13:12] == 2'd1) exp_crc = sinc(exp_crc);
    chk(vcnt == (m[13:12] == 2'd0 ? 1 : 0), {tag, " valid pulses"}, vcnt, m[13:12] == 2'd0);
    if (m[13:12] == 2'd0) chk(vlast == m[11:0], {tag, " erpm"}, vlast, m[11:0]);
    check_counters(tag);
  endtask

  task automatic good_word(output logic [19:0] w, input bit bad_ck);
    logic [11:0] p;
    logic [3:0] c;
    do begin
      p = 12'($urandom);
      c = 4'hF ^ p[11:8] ^ p[7:4] ^ p[3:0];
      if (bad_ck) c = c ^ 4'(1 + ($urandom % 15));
      w = build(p, c);
    end while (!w[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] w;
    void'($urandom(32'd20231219));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(erpm_o == 0 && !erpm_valid_o, "R1 outputs after reset", erpm_o, 0);
    check_counters("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 unarmed line activity
    vcnt = 0;
    send(20'h5A3C1, 8, 20);
    repeat (20) @(negedge clk);
    chk(vcnt == 0, "R10 no valid when unarmed", vcnt, 0);
    check_counters("R10");

    // R2 R5 R7 good frames at several periods
    for (int k = 0; k < 6; k++) begin
      good_word(w, 1'b0);
      do_frame(w, 8, 8, "R2 R5 R7 good div8");
    end
    good_word(w, 1'b0);
    do_frame(w, 12, 12, "R2 good div12");
    good_word(w, 1'b0);
    do_frame(w, 5, 5, "R2 good div5");
    // directed: payload all ones maps erpm 0
    w = build(12'hFFF, 4'hF ^ 4'hF ^ 4'hF ^ 4'hF);
    do_frame(w, 8, 8, "R5 R7 directed");

    // R3 slow line resynchronised on rising edges
    for (int k = 0; k < 4; k++) begin
      good_word(w, 1'b0);
      do_frame(w, 16, 17, "R3 slow line");
    end

    // R4 framing error
    w = 20'hABCDE & ~20'h1;
    do_frame(w, 8, 8, "R4 framing");

    // R6 checksum error
    for (int k = 0; k < 3; k++) begin
      good_word(w, 1'b1);
      do_frame(w, 8, 8, "R6 checksum");
    end

    // R8 missing reply: repeated start, then abort mid-frame
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    check_counters("R8 repeated start");
    bit_div_i = 16'd8;
    good_word(w, 1'b0);
    send(w, 8, 6);
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    check_counters("R8 abort mid-frame");
    good_word(w, 1'b0);
    do_frame(w, 8, 8, "R8 after abort");

    // random frames
    for (int k = 0; k < 25; k++) begin
      w = 20'($urandom);
      do_frame(w, 8, 8, "R4 R5 R6 random");
    end

    // R9 saturation of miss and frame counters
    for (int k = 0; k < 18; k++) pulse_start();
    repeat (3) @(negedge clk);
    chk(miss_cnt_o == CMAX, "R9 miss saturates", miss_cnt_o, CMAX);
    for (int k = 0; k < 17; k++) do_frame(20'h13570, 4, 4, "R9 frame saturation");
    chk(frame_err_cnt_o == CMAX, "R9 frame saturates", frame_err_cnt_o, CMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule